// File: doc/BRIEF.md
# Banked Address Extender for an 8-bit Processor

This block widens the reach of a processor that has an 8-bit data bus and a 16-bit address bus from 64K to 256K bytes. The lower half of the processor space is a window onto one of eight 32K-byte banks of physical memory. The upper half of the space holds no memory. Writing there stores a bank number taken from the data bus. That number then forms the top bits of every physical address that follows.

The block drives an 18-bit physical address and a memory enable toward the memory system. For checking, it also contains a behavioural byte store behind that address. The store keeps the full bank number but only the low `MEM_OFS_W` offset bits, so at default parameters the storage stays small. The processor reads memory through the window. It can also read back the current bank number from the upper half of the space.

Top module: `bank_mapper`

## Requirements
- R1: `phys_addr[14:0]` always equals `cpu_addr[14:0]`, whether or not a strobe is active.
- R2: `phys_addr[17:15]` always equals the bank register as it stood before the current clock edge.
- R3: `mem_en` is 1 exactly when `cpu_addr[15]` is 0 and `cpu_we` or `cpu_re` is 1. When `cpu_addr[15]` is 1, `mem_en` is 0.
- R4: A cycle with `cpu_we`=1 and `cpu_addr[15]`=1 loads the bank register from `cpu_wdata[2:0]` at the clock edge. Data bits 7:3 have no effect on the stored bank.
- R5: A bank write does not change `phys_addr` during its own cycle. The new bank first appears in the next cycle.
- R6: After reset the bank register holds 0.
- R7: While `cpu_addr[15]` is 1, `cpu_rdata` shows the bank number in bits 2:0 and zeros in bits 7:3.
- R8: A write with `cpu_addr[15]`=0 stores `cpu_wdata` at physical byte {bank, offset}. A read with `cpu_addr[15]`=0 returns that byte combinationally. A byte written under one bank is not seen under another bank. Neither a bank write nor a bank read alters stored bytes.
- R9: The bank register keeps its value in every cycle that is not a bank write. This includes reads of the upper half.
- R10: When `cpu_we` and `cpu_re` are both 1, the cycle acts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data: a stored byte, or the bank number when bit 15 is set |
| phys_addr | output | 18 | Physical address {bank, offset} |
| mem_en | output | 1 | Memory access enable |

## Verification
The hardest case to reach is the cycle in which a bank write and the physical address it must not yet affect happen together. Here the old bank has to show on the address pins while the new value is on the data bus. The stimulus drives bank writes back to back, and also puts a memory access directly after a bank switch. It then reads bytes back under the other banks to show that each write landed in its own bank. Bank writes carry junk in data bits 7:3 so that the masking is exercised.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

   typedef enum logic [2:0] {
      ACC_IDLE    = 3'd0,
      ACC_MEM_RD  = 3'd1,
      ACC_MEM_WR  = 3'd2,
      ACC_BANK_RD = 3'd3,
      ACC_BANK_WR = 3'd4
   } acc_kind_e;

   // Writes win over reads when both strobes are raised.
   function automatic acc_kind_e classify(input logic hi, input logic we, input logic re);
      if (we)      return hi ? ACC_BANK_WR : ACC_MEM_WR;
      else if (re) return hi ? ACC_BANK_RD : ACC_MEM_RD;
      else         return ACC_IDLE;
   endfunction

endpackage

// File: rtl/bmap_decode.sv
module bmap_decode
   import bmap_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BANK_W = 3,
   localparam int OFS_W  = ADDR_W - 1,
   localparam int PHYS_W = BANK_W + OFS_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   input  logic [BANK_W-1:0] bank,
   output logic [PHYS_W-1:0] phys,
   output logic              mem_en,
   output logic              mem_wr,
   output logic              bank_ld,
   output logic              bank_sel
);

   acc_kind_e kind;

   always_comb begin
      kind     = classify(addr[ADDR_W-1], we, re);
      phys     = {bank, addr[OFS_W-1:0]};
      mem_en   = (kind == ACC_MEM_RD) || (kind == ACC_MEM_WR);
      mem_wr   = (kind == ACC_MEM_WR);
      bank_ld  = (kind == ACC_BANK_WR);
      bank_sel = addr[ADDR_W-1];
   end

endmodule

// File: rtl/bmap_bank_reg.sv
module bmap_bank_reg #(
   parameter int DATA_W = 8,
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_data,
   output logic [BANK_W-1:0] bank_q
);

   initial begin
      assert (BANK_W >= 1 && BANK_W <= DATA_W)
         else $fatal(1, "bank width must fit the data bus");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     bank_q <= '0;
      else if (ld_en) bank_q <= ld_data[BANK_W-1:0];
   end

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> bank_q == $past(ld_data[BANK_W-1:0]));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(bank_q));

endmodule

// File: rtl/bmap_store.sv
module bmap_store #(
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 3,
   parameter int OFS_W     = 15,
   parameter int MEM_OFS_W = 6,
   localparam int IDX_W    = BANK_W + MEM_OFS_W,
   localparam int DEPTH    = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] bank,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   initial begin
      assert (MEM_OFS_W >= 1 && MEM_OFS_W <= OFS_W)
         else $fatal(1, "stored offset width out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  idx;

   generate
      if (MEM_OFS_W == OFS_W) begin : g_full
         assign idx = {bank, ofs};
      end else begin : g_alias
         assign idx = {bank, ofs[MEM_OFS_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 3,
   parameter int MEM_OFS_W = 6,
   localparam int OFS_W    = ADDR_W - 1,
   localparam int PHYS_W   = BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_we,
   input  logic              cpu_re,
   output logic [7:0]        cpu_rdata,
   output logic [17:0]       phys_addr,
   output logic              mem_en
);

   initial begin
      assert (ADDR_W == 16 && DATA_W == 8 && BANK_W == 3)
         else $fatal(1, "port widths are fixed at 16/8/3");
   end

   logic [BANK_W-1:0] bank_q;
   logic              mem_wr, bank_ld, bank_sel;
   logic [DATA_W-1:0] store_rd;

   bmap_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
      .addr    (cpu_addr),
      .we      (cpu_we),
      .re      (cpu_re),
      .bank    (bank_q),
      .phys    (phys_addr),
      .mem_en  (mem_en),
      .mem_wr  (mem_wr),
      .bank_ld (bank_ld),
      .bank_sel(bank_sel)
   );

   bmap_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (bank_ld),
      .ld_data(cpu_wdata),
      .bank_q (bank_q)
   );

   bmap_store #(.DATA_W(DATA_W), .BANK_W(BANK_W), .OFS_W(OFS_W),
                .MEM_OFS_W(MEM_OFS_W)) u_store (
      .clk  (clk),
      .wr_en(mem_wr),
      .bank (bank_q),
      .ofs  (cpu_addr[OFS_W-1:0]),
      .wdata(cpu_wdata),
      .rdata(store_rd)
   );

   assign cpu_rdata = bank_sel ? {{(DATA_W-BANK_W){1'b0}}, bank_q} : store_rd;

   p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

   p_bank_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[PHYS_W-1 -: BANK_W] == bank_q);

   p_no_mem_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[ADDR_W-1] |-> !mem_en);

   p_bank_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_re && cpu_addr[ADDR_W-1]) |-> cpu_rdata == {{(DATA_W-BANK_W){1'b0}}, bank_q});

   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_re && !cpu_addr[ADDR_W-1]) |-> mem_en);

endmodule

// File: tb/bank_mapper_tb_top.sv
`timescale 1ns/1ps
module bank_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_we = 1'b0;
   logic        cpu_re = 1'b0;
   logic [7:0]  cpu_rdata;
   logic [17:0] phys_addr;
   logic        mem_en;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int          m_bank = 0;
   logic [7:0]  m_mem [int];

   always #2 clk = ~clk;

   bank_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
      .phys_addr(phys_addr), .mem_en(mem_en)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One processor cycle: drive, compare against model, advance model at the edge.
   task automatic cyc(input bit we, input bit re, input logic [15:0] a, input logic [7:0] d);
      int key;
      logic [17:0] exp_pa;
      bit exp_en;
      cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = d;
      #1;
      exp_pa = 18'(m_bank * 32768 + int'(a[14:0]));
      exp_en = !a[15] && (we || re);
      check(phys_addr == exp_pa, "R1 R2 R5 phys_addr", phys_addr, exp_pa);
      check(mem_en == exp_en, "R3 R10 mem_en", mem_en, exp_en);
      key = m_bank * 32768 + int'(a[14:0]);
      if (re && !we) begin
         if (a[15])
            check(cpu_rdata == 8'(m_bank), "R7 bank readback", cpu_rdata, m_bank);
         else if (m_mem.exists(key))
            check(cpu_rdata == m_mem[key], "R8 stored byte", cpu_rdata, m_mem[key]);
      end
      @(posedge clk);
      if (we) begin
         if (a[15]) m_bank = int'(d[2:0]);
         else       m_mem[key] = d;
      end
      @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6: reset value visible on bank readback and address top bits
      cyc(0, 1, 16'h8000, 8'h00);
      check(phys_addr[17:15] == 3'd0, "R6 reset bank", phys_addr[17:15], 0);
      // R4 with junk upper bits; R5 old bank during the write itself
      cpu_we = 1; cpu_addr = 16'h8123; cpu_wdata = 8'hFD; #1;
      check(phys_addr[17:15] == 3'd0, "R5 same-cycle bank", phys_addr[17:15], 0);
      check(mem_en == 1'b0, "R3 bank write no mem_en", mem_en, 0);
      @(posedge clk); m_bank = 5; @(negedge clk);
      cpu_we = 0; cpu_re = 1; cpu_addr = 16'h8000; #1;
      check(cpu_rdata == 8'h05, "R4 R7 masked bank load", cpu_rdata, 5);
      check(phys_addr == {3'd5, 15'h0000}, "R5 next-cycle bank", phys_addr, {3'd5, 15'h0});
      @(negedge clk);
      // R1: top offset
      cyc(0, 0, 16'h7FFF, 8'h00);
      check(phys_addr == {3'd5, 15'h7FFF}, "R1 top offset", phys_addr, {3'd5, 15'h7FFF});
      // R8: same offset in every bank, then read back each
      for (int b = 0; b < 8; b++) begin
         cyc(1, 0, 16'h8000, 8'(b | 8'hA8));
         cyc(1, 0, 16'h0010, 8'(8'h30 + b));
      end
      cyc(0, 1, 16'h8000, 8'h00);  // R9 bank read keeps bank
      for (int b = 7; b >= 0; b--) begin
         cyc(1, 0, 16'h8000, 8'(b));
         cyc(0, 1, 16'h0010, 8'h00);
         check(cpu_rdata == 8'(8'h30 + b), "R8 per-bank byte", cpu_rdata, 8'h30 + b);
      end
      // R10: both strobes act as a write
      cyc(1, 1, 16'h0011, 8'h77);
      cyc(0, 1, 16'h0011, 8'h00);
      check(cpu_rdata == 8'h77, "R10 write wins", cpu_rdata, 8'h77);
      // R9: read of upper half does not move bank
      cyc(0, 1, 16'hFFFF, 8'hFF);
      cyc(0, 1, 16'h8000, 8'h00);
      check(cpu_rdata == 8'h00, "R9 bank held", cpu_rdata, 0);
      // Mixed stimulus compared every cycle against the model
      for (int i = 0; i < 3000; i++) begin
         int sel;
         logic [15:0] a;
         sel = int'($urandom % 8);
         a = 16'($urandom);
         case (sel)
            0, 1: cyc(1, 0, a | 16'h8000, 8'($urandom));
            2, 3: cyc(1, 0, a & 16'h003F, 8'($urandom));
            4, 5: cyc(0, 1, a & 16'h003F, 8'h00);
            6:    cyc(0, 1, a | 16'h8000, 8'($urandom));
            default: cyc(0, 0, a, 8'($urandom));
         endcase
      end
      // R6: reset again returns bank to 0, stored bytes kept by model
      rst_n = 0; @(negedge clk); rst_n = 1; m_bank = 0;
      cyc(0, 1, 16'h8000, 8'h00);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule